// File: doc/BRIEF.md
# Per-Instruction Port Strobe Generator

This block serves a microcontroller that has no shared data bus. Alongside every instruction word the controller fetches an extra select byte. The block turns that byte into one read strobe and one write strobe for the devices on an 8-bit active-low I/O bus. One instruction can therefore read from any port and write to any other port.

The select byte is captured when the instruction pulse `mclk` ends, and the captured code is held for the whole instruction. The read field feeds one one-of-eight decoder and the write field feeds a separate one. The write-control input `wr_ctl` picks which decoder is active:

- While `wr_ctl` is low (the first half cycle), the read decoder may drive.
- While `wr_ctl` is high (the second half cycle), only the write decoder drives.

A delayed copy of the instruction pulse, `mclk_dly`, blanks the read strobes at the end of each instruction. Two reads in a row from the same port therefore still produce two separate edges.

The read code 7 is a dummy port for instructions that need no input data. The block also produces a combined active-low flag that marks any port access, taken from write-control and select-control.

All control inputs are sampled by the system clock `clk`.

Top module: `fio_strobe_gen`

## Requirements
- R1: While reset is held and in the first cycles after it, every bit of `rd_n` and `wr_n` reads 1 (all strobes inactive), whatever the levels of `wr_ctl` and `mclk_dly`.
- R2: `sel_in` is captured on the first `clk` rising edge at which `mclk` is sampled low after being sampled high. Between such edges, changes on `sel_in` have no effect on the strobes.
- R3: With `wr_ctl`=0 and `mclk_dly`=0, exactly bit `sel_in[2:0]` of `rd_n` is 0 (the read code captured per R2), for codes 0 to 6. In the same condition all bits of `wr_n` are 1.
- R4: With `wr_ctl`=1, exactly bit `sel_in[5:3]` of `wr_n` is 0 (the captured write code, 0 to 7), and all bits of `rd_n` are 1.
- R5: While `mclk_dly`=1, all bits of `rd_n` are 1. Two consecutive reads of the same port therefore show a rising and a falling edge between them.
- R6: Read code 7 is a dummy port: `rd_n[7]` is always 1, and a captured read code of 7 leaves all of `rd_n` at 1.
- R7: `io_any_n` is 0 exactly when `wr_ctl` or `sel_ctl` is 1.
- R8: The read and write fields are decoded independently. Any pair of read and write codes, including equal ones, is honoured in one instruction.
- R9: At most one bit of `rd_n` and at most one bit of `wr_n` is 0 at any time.
- R10: After reset, no strobe goes low until the first select byte has been captured. This holds even with `wr_ctl`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all control inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_in | input | 6 | Select byte fetched with the instruction: [2:0] read code, [5:3] write code |
| mclk | input | 1 | Active-high instruction pulse; its trailing edge captures `sel_in` |
| mclk_dly | input | 1 | Delayed instruction pulse; high blanks all read strobes |
| wr_ctl | input | 1 | Write-control: 0 enables the read decoder, 1 enables the write decoder |
| sel_ctl | input | 1 | Select-control: marks an address phase on the I/O bus |
| rd_n | output | 8 | Active-low read strobes, one per port; bit 7 is the dummy and stays high |
| wr_n | output | 8 | Active-low write strobes, one per port |
| io_any_n | output | 1 | Active-low flag for any port access |

## Verification
The checker watches these rules on every cycle:
- no more than one read strobe and one write strobe low at a time;
- read strobes high while `wr_ctl` or `mclk_dly` is high;
- write strobes high while `wr_ctl` is low;
- the dummy read line never low;
- the captured code held between trailing edges of `mclk`;
- silence until the first capture after reset.

Only the bench's scenarios can show which port a given code selects. The same holds for the capture landing on the trailing-edge cycle rather than earlier, for back-to-back reads of one port producing a fresh edge, and for the access flag following its two inputs.

// File: rtl/fio_pkg.sv
package fio_pkg;

  // Width of one code field in the select byte
  localparam int CODE_W_DEF = 3;

  // True when a decoder output bit is selected by the latched code
  function automatic logic code_hit(input int unsigned code,
                                    input int unsigned idx,
                                    input logic        en,
                                    input logic        is_dummy);
    return en && (code == idx) && !is_dummy;
  endfunction

  // Capture point: the sample just after mclk has fallen
  function automatic logic trailing(input logic prev, input logic now);
    return prev && !now;
  endfunction

endpackage

// File: rtl/fio_capture.sv
module fio_capture
  import fio_pkg::*;
#(
  parameter int CODE_W = CODE_W_DEF,
  localparam int SEL_W = 2 * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic              mclk,
  output logic [CODE_W-1:0] rd_code,
  output logic [CODE_W-1:0] wr_code,
  output logic              armed,
  output logic              cap_evt
);

  localparam logic [CODE_W-1:0] RD_IDLE = {CODE_W{1'b1}};

  logic mclk_q;

  // Capture on the trailing edge of the instruction pulse
  assign cap_evt = trailing(mclk_q, mclk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mclk_q  <= 1'b0;
      rd_code <= RD_IDLE;
      wr_code <= '0;
      armed   <= 1'b0;
    end else begin
      mclk_q <= mclk;
      if (cap_evt) begin
        rd_code <= sel_in[CODE_W-1:0];
        wr_code <= sel_in[SEL_W-1:CODE_W];
        armed   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fio_decode.sv
module fio_decode
  import fio_pkg::*;
#(
  parameter int CODE_W    = CODE_W_DEF,
  parameter bit HAS_DUMMY = 1'b0,
  localparam int NPORT    = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code,
  input  logic              en,
  output logic [NPORT-1:0]  strb_n
);

  // One active-low output per port; the top code may be a dummy
  for (genvar i = 0; i < NPORT; i++) begin : g_port
    localparam bit IS_DUMMY = HAS_DUMMY && (i == NPORT - 1);
    assign strb_n[i] = ~code_hit(int'(code), i, en, IS_DUMMY);
  end

endmodule

// File: rtl/fio_strobe_gen.sv
module fio_strobe_gen
  import fio_pkg::*;
#(
  parameter int CODE_W = CODE_W_DEF,
  localparam int NPORT = 1 << CODE_W,
  localparam int SEL_W = 2 * CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             mclk,
  input  logic             mclk_dly,
  input  logic             wr_ctl,
  input  logic             sel_ctl,
  output logic [NPORT-1:0] rd_n,
  output logic [NPORT-1:0] wr_n,
  output logic             io_any_n
);

  logic [CODE_W-1:0] rd_code;
  logic [CODE_W-1:0] wr_code;
  logic              armed;
  logic              cap_evt;
  logic              rd_en;
  logic              wr_en;

  fio_capture #(.CODE_W(CODE_W)) i_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_in  (sel_in),
    .mclk    (mclk),
    .rd_code (rd_code),
    .wr_code (wr_code),
    .armed   (armed),
    .cap_evt (cap_evt)
  );

  // Alternate enables; reads blanked at instruction end
  assign rd_en = armed && !wr_ctl && !mclk_dly;
  assign wr_en = armed && wr_ctl;

  fio_decode #(.CODE_W(CODE_W), .HAS_DUMMY(1'b1)) i_rd_dec (
    .code   (rd_code),
    .en     (rd_en),
    .strb_n (rd_n)
  );

  fio_decode #(.CODE_W(CODE_W), .HAS_DUMMY(1'b0)) i_wr_dec (
    .code   (wr_code),
    .en     (wr_en),
    .strb_n (wr_n)
  );

  // Any port access, active low
  assign io_any_n = ~(wr_ctl | sel_ctl);

endmodule

// File: rtl/fio_strobe_chk.sv
module fio_strobe_chk #(
  parameter int CODE_W = 3,
  localparam int NPORT = 1 << CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mclk_dly,
  input logic              wr_ctl,
  input logic [NPORT-1:0]  rd_n,
  input logic [NPORT-1:0]  wr_n,
  input logic [CODE_W-1:0] rd_code,
  input logic [CODE_W-1:0] wr_code,
  input logic              armed,
  input logic              cap_evt
);

  // R9
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~rd_n));
  // R9
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~wr_n));
  // R5
  rd_blank_end_chk: assert property (@(posedge clk) disable iff (!rst_n) mclk_dly |-> (&rd_n));
  // R4
  rd_quiet_wr_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_ctl |-> (&rd_n));
  // R3
  wr_quiet_rd_chk: assert property (@(posedge clk) disable iff (!rst_n) !wr_ctl |-> (&wr_n));
  // R6
  dummy_port_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_n[NPORT-1]);
  // R2
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> ($stable(rd_code) && $stable(wr_code)));
  // R10
  silent_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> ((&rd_n) && (&wr_n)));

endmodule

bind fio_strobe_gen fio_strobe_chk #(.CODE_W(CODE_W)) i_fio_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mclk_dly (mclk_dly),
  .wr_ctl   (wr_ctl),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .rd_code  (rd_code),
  .wr_code  (wr_code),
  .armed    (armed),
  .cap_evt  (cap_evt)
);

// File: tb/test_fio_strobe_gen.sv
module test_fio_strobe_gen;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] sel_in = 6'd0;
  logic       mclk = 1'b0;
  logic       mclk_dly = 1'b0;
  logic       wr_ctl = 1'b0;
  logic       sel_ctl = 1'b0;
  logic [7:0] rd_n;
  logic [7:0] wr_n;
  logic       io_any_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fio_strobe_gen i_fio_strobe_gen (
    .clk(clk), .rst_n(rst_n), .sel_in(sel_in), .mclk(mclk),
    .mclk_dly(mclk_dly), .wr_ctl(wr_ctl), .sel_ctl(sel_ctl),
    .rd_n(rd_n), .wr_n(wr_n), .io_any_n(io_any_n)
  );

  // {rd code, wr code, expected rd_n, expected wr_n}
  localparam int NVEC = 8;
  localparam logic [21:0] VEC [NVEC] = '{
    {3'd0, 3'd5, 8'hFE, 8'hDF},
    {3'd3, 3'd3, 8'hF7, 8'hF7},
    {3'd6, 3'd0, 8'hBF, 8'hFE},
    {3'd7, 3'd7, 8'hFF, 8'h7F},
    {3'd1, 3'd2, 8'hFD, 8'hFB},
    {3'd2, 3'd6, 8'hFB, 8'hBF},
    {3'd4, 3'd1, 8'hEF, 8'hFD},
    {3'd5, 3'd4, 8'hDF, 8'hEF}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One instruction: pulse mclk with the select byte, end with read phase open
  task automatic instr(input logic [2:0] rd, input logic [2:0] wr);
    @(negedge clk);
    mclk = 1'b1; mclk_dly = 1'b1; wr_ctl = 1'b0; sel_in = {wr, rd};
    @(negedge clk);
    mclk = 1'b0;
    @(negedge clk);
    mclk_dly = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: strobes idle during reset
    #1; chk("R1 rd in reset", rd_n, 8'hFF);
    wr_ctl = 1'b1; #1; chk("R1 wr in reset", wr_n, 8'hFF);
    wr_ctl = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 rd after reset", rd_n, 8'hFF);
    // R10: nothing before first capture, even with wr_ctl high
    wr_ctl = 1'b1; #1; chk("R10 wr unarmed", wr_n, 8'hFF);
    sel_in = 6'b000_000; @(negedge clk); wr_ctl = 1'b0; #1;
    chk("R10 rd unarmed", rd_n, 8'hFF);

    // R3 R4 R8 table of read/write pairs
    for (int k = 0; k < NVEC; k++) begin
      instr(VEC[k][21:19], VEC[k][18:16]);
      chk("R3 R6 read phase", rd_n, VEC[k][15:8]);
      chk("R3 wr idle in read", wr_n, 8'hFF);
      @(negedge clk); wr_ctl = 1'b1; #1;
      chk("R4 R8 write phase", wr_n, VEC[k][7:0]);
      chk("R4 rd idle in write", rd_n, 8'hFF);
      @(negedge clk); wr_ctl = 1'b0; mclk_dly = 1'b1; #1;
      chk("R5 rd blanked at end", rd_n, 8'hFF);
    end

    // R2: capture happens on the trailing edge, not while mclk is high
    instr(3'd2, 3'd3);
    chk("R2 base read", rd_n, 8'hFB);
    sel_in = {3'd6, 3'd5};
    repeat (3) @(negedge clk); #1;
    chk("R2 rd held", rd_n, 8'hFB);
    wr_ctl = 1'b1; #1; chk("R2 wr held", wr_n, 8'hF7);
    wr_ctl = 1'b0;
    // mclk high alone does not capture yet
    @(negedge clk); mclk = 1'b1; sel_in = {3'd1, 3'd4};
    @(negedge clk); #1;
    chk("R2 no capture while high", rd_n, 8'hFB);
    mclk = 1'b0;
    @(negedge clk); #1;
    chk("R2 capture after fall", rd_n, 8'hEF);

    // R5: back-to-back reads of one port show an edge between them
    instr(3'd4, 3'd0);
    chk("R5 first read", rd_n, 8'hEF);
    @(negedge clk); mclk_dly = 1'b1; #1;
    chk("R5 gap between reads", rd_n, 8'hFF);
    instr(3'd4, 3'd0);
    chk("R5 second read", rd_n, 8'hEF);

    // R6: dummy code 7 yields no read strobe
    instr(3'd7, 3'd1);
    chk("R6 dummy read", rd_n, 8'hFF);

    // R7: access flag against both control inputs
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); wr_ctl = c[0]; sel_ctl = c[1]; #1;
      chk("R7 access flag", {7'd0, io_any_n}, {7'd0, (c == 0)});
    end
    wr_ctl = 1'b0; sel_ctl = 1'b0;

    // R1 R10: reset again clears the captured codes
    instr(3'd0, 3'd0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 rd after re-reset", rd_n, 8'hFF);
    wr_ctl = 1'b1; #1; chk("R10 wr after re-reset", wr_n, 8'hFF);
    wr_ctl = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule